// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine lands incoming frames in buffers that host software owns, steered by a ring of sixteen receive descriptors kept in a shared memory. The engine reaches that memory through a simple port of 16-bit words with a fixed one-cycle read latency. Each descriptor takes four consecutive words at `DESC_BASE + 4*entry`:

- word 0: low buffer address
- word 1: status byte in bits 15:8 and high address in bits 7:0
- word 2: negative buffer length
- word 3: received count

The engine never reads the address words or the length word. Each entry's buffer instead sits at a fixed place: `BUF_BASE + entry*772` words, which is 1544 bytes packed big-endian, two bytes to a word.

Software hands an entry to the engine by writing its status byte as exactly 0x80. When a frame starts, the engine searches the ring from its current index for such an entry. On a hit it does four things:

- It streams the frame bytes into that entry's buffer.
- It records the byte count.
- It rewrites the status byte to mark a complete packet that software owns again.
- It steps the index and pulses a receive-done event.

A background scan keeps a map of handed-over entries. The capacity output reports whether a frame could be accepted.

The frame input is valid/ready with a last marker. A beat moves on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the engine is idle, searching, or writing back the count and status. It is high while the engine stores or discards frame bytes. The sender must hold `in_data` and `in_last` steady while it waits.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `capacity` is 0, `in_ready` is 0, `rx_done` is 0 and the ring index is 0.
- R2: An entry is usable only when its status byte (word 1 bits 15:8) equals exactly 0x80. Any other value, such as 0x81, is passed over.
- R3: The search examines entries in rising order, modulo 16, starting at the index. It never examines the entry at index−1. If no usable entry is found, the frame is dropped.
- R4: Frame byte j goes to word `BUF_BASE + entry*772 + j/2`. An even j is written to bits 15:8 with strobe 2'b10 and bits 7:0 zero. An odd j is written to bits 7:0 with strobe 2'b01 and bits 15:8 zero.
- R5: After the last byte, the engine writes word 3 with the byte count, bytes swapped (`{cnt[7:0],cnt[15:8]}`), strobe 2'b11. It then writes word 1 as 16'h0300 with strobe 2'b10. The status write is the last memory write of the frame.
- R6: With the status write, `rx_done` is high for exactly one cycle, and the index becomes index+1 modulo 16, whichever entry was used.
- R7: A dropped frame is consumed with `in_ready` high up to its last beat. It causes no memory write and no `rx_done`, and it leaves the index unchanged.
- R8: `in_ready` is low in the cycle a frame first presents `in_valid` and during the count and status write-back. No memory read happens while `in_ready` is high.
- R9: `capacity` is 1544 when the scan map holds any handed-over entry among all 16, and 0 otherwise. An entry that is filled drops out of the map on the edge that ends the `rx_done` cycle.
- R10: While `stopped` is high, `capacity` is 0 and a starting frame is dropped as in R7.
- R11: Bytes after the first 1544 of a frame are accepted and discarded. The count saturates at 1544.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stopped | input | 1 | Controller stopped: no reception, capacity 0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Engine accepts the byte |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_wstrb | output | 2 | Byte lane strobes (bit 1 = bits 15:8) |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |
| rx_done | output | 1 | One-cycle frame-stored event |
| capacity | output | 16 | Bytes acceptable: 1544 or 0 |

## Verification
Two functions meet in a single cycle: the status write-back that completes a frame, and the capacity report derived from the ownership map. The bench hands over one single entry, fills it, and samples `capacity` both in the `rx_done` cycle and in the cycle after. It expects 1544 and then 0, because filling the only handed-over entry removes it from the map on that edge. A second meeting point is a frame starting while a background scan read is in flight. Frames sent with idle gaps between beats provoke it, and the scoreboard of expected memory writes judges the result.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN_WT,
    ST_SRCH_RD,
    ST_SRCH_WT,
    ST_DATA,
    ST_LEN,
    ST_FLAG,
    ST_DROP
  } rxr_state_e;

  localparam logic [7:0] FLAG_HANDED = 8'h80;
  localparam logic [7:0] FLAG_DONE   = 8'h03;
  localparam int DESC_WORDS = 4;
  localparam int FLAG_OFS   = 1;
  localparam int CNT_OFS    = 3;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

endpackage

// File: rtl/rxr_own_map.sv
module rxr_own_map #(
  parameter int RING_LOG = 4,
  parameter int CAP_W    = 16,
  parameter int CAPACITY = 1544
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stopped,
  input  logic                scan_adv,
  input  logic                wr_en,
  input  logic [RING_LOG-1:0] wr_idx,
  input  logic                wr_owned,
  output logic [RING_LOG-1:0] scan_ptr,
  output logic [CAP_W-1:0]    capacity
);
  localparam int ENTRIES = 1 << RING_LOG;

  logic [ENTRIES-1:0] owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned    <= '0;
      scan_ptr <= '0;
    end else begin
      if (wr_en) owned[wr_idx] <= wr_owned;
      if (scan_adv) scan_ptr <= scan_ptr + 1'b1;
    end
  end

  assign capacity = (!stopped && (|owned)) ? CAP_W'(CAPACITY) : '0;

endmodule

// File: rtl/rxr_byte_pack.sv
module rxr_byte_pack #(
  parameter int LANES = 2,
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             en,
  input  logic [7:0]       byte_in,
  input  logic [OFS_W-1:0] ofs,
  output logic [8*LANES-1:0] wdata,
  output logic [LANES-1:0]   strb
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic sel;
    assign sel = en && (ofs == OFS_W'(LANES - 1 - g));
    assign wdata[8*g +: 8] = sel ? byte_in : 8'h00;
    assign strb[g] = sel;
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int RING_LOG  = 4,
  parameter int AW        = 16,
  parameter int BUF_BYTES = 1544,
  parameter int DESC_BASE = 0,
  parameter int BUF_BASE  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stopped,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic [1:0]    mem_wstrb,
  input  logic [15:0]   mem_rdata,
  output logic          rx_done,
  output logic [15:0]   capacity
);
  localparam int BUF_WORDS = (BUF_BYTES + 1) / 2;
  localparam logic [15:0] BUF_LIMIT = 16'(BUF_BYTES);

  rxr_state_e state;
  logic [RING_LOG-1:0] idx, cur, stop_at, slot, scan_ptr;
  logic [15:0] cnt;
  logic hit, room, store_beat;
  logic map_wr, map_owned, scan_adv;
  logic [RING_LOG-1:0] map_idx;
  logic [15:0] pack_wdata;
  logic [1:0]  pack_strb;
  logic unused_lo;

  assign unused_lo = ^mem_rdata[7:0];
  assign hit  = (mem_rdata[15:8] == FLAG_HANDED);
  assign room = (cnt < BUF_LIMIT);
  assign store_beat = (state == ST_DATA) && in_valid && room;

  function automatic logic [AW-1:0] desc_word(input logic [RING_LOG-1:0] e, input int ofs);
    return AW'(DESC_BASE) + AW'(e) * AW'(DESC_WORDS) + AW'(ofs);
  endfunction

  rxr_own_map #(.RING_LOG(RING_LOG), .CAP_W(16), .CAPACITY(BUF_BYTES)) u_map (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .scan_adv(scan_adv),
    .wr_en(map_wr), .wr_idx(map_idx), .wr_owned(map_owned),
    .scan_ptr(scan_ptr), .capacity(capacity)
  );

  rxr_byte_pack #(.LANES(2)) u_pack (
    .en(store_beat), .byte_in(in_data), .ofs(cnt[0]),
    .wdata(pack_wdata), .strb(pack_strb)
  );

  // Map updates: scan capture, search capture, clear on completion
  always_comb begin
    map_wr = 1'b0; map_owned = 1'b0; map_idx = scan_ptr; scan_adv = 1'b0;
    case (state)
      ST_SCAN_WT: begin map_wr = 1'b1; map_owned = hit; scan_adv = 1'b1; end
      ST_SRCH_WT: begin map_wr = 1'b1; map_owned = hit; map_idx = cur; end
      ST_FLAG:    begin map_wr = 1'b1; map_owned = 1'b0; map_idx = slot; end
      default: ;
    endcase
  end

  // Memory port and stream handshake
  always_comb begin
    mem_re = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_wstrb = '0;
    in_ready = 1'b0;
    case (state)
      ST_IDLE: begin
        mem_re   = !in_valid;
        mem_addr = desc_word(scan_ptr, FLAG_OFS);
      end
      ST_SRCH_RD: begin
        mem_re   = 1'b1;
        mem_addr = desc_word(cur, FLAG_OFS);
      end
      ST_DATA: begin
        in_ready  = 1'b1;
        mem_we    = store_beat;
        mem_addr  = AW'(BUF_BASE) + AW'(slot) * AW'(BUF_WORDS) + AW'(cnt[15:1]);
        mem_wdata = pack_wdata;
        mem_wstrb = pack_strb;
      end
      ST_LEN: begin
        mem_we    = 1'b1;
        mem_addr  = desc_word(slot, CNT_OFS);
        mem_wdata = swap16(cnt);
        mem_wstrb = 2'b11;
      end
      ST_FLAG: begin
        mem_we    = 1'b1;
        mem_addr  = desc_word(slot, FLAG_OFS);
        mem_wdata = {FLAG_DONE, 8'h00};
        mem_wstrb = 2'b10;
      end
      ST_DROP: in_ready = 1'b1;
      default: ;
    endcase
  end

  assign rx_done = (state == ST_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      cur     <= '0;
      stop_at <= '0;
      slot    <= '0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            cur     <= idx;
            stop_at <= idx - 1'b1;
            state   <= stopped ? ST_DROP : ST_SRCH_RD;
          end else begin
            state <= ST_SCAN_WT;
          end
        end
        ST_SCAN_WT: state <= ST_IDLE;
        ST_SRCH_RD: state <= ST_SRCH_WT;
        ST_SRCH_WT: begin
          if (hit) begin
            slot  <= cur;
            cnt   <= '0;
            state <= ST_DATA;
          end else if (cur + 1'b1 == stop_at) begin
            state <= ST_DROP;
          end else begin
            cur   <= cur + 1'b1;
            state <= ST_SRCH_RD;
          end
        end
        ST_DATA: begin
          if (in_valid) begin
            if (room) cnt <= cnt + 1'b1;
            if (in_last) state <= ST_LEN;
          end
        end
        ST_LEN: state <= ST_FLAG;
        ST_FLAG: begin
          idx   <= idx + 1'b1;
          state <= ST_IDLE;
        end
        ST_DROP: if (in_valid && in_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Guards
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (idx == $past(idx) + 1'b1));
  p_flag_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_we && mem_wstrb == 2'b10 && mem_wdata == 16'h0300));
  p_count_before_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ($past(mem_we) && $past(mem_wstrb) == 2'b11));
  p_read_blocks_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !in_ready);
  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> !mem_we);
  p_single_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_stopped_no_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && state == ST_IDLE && in_valid) |=> !mem_we);

endmodule

// File: tb/test_rx_ring_engine.sv
`timescale 1ns/100ps
module test_rx_ring_engine;
  localparam int AW = 16;
  localparam int DESC = 0;
  localparam int BUFB = 64;
  localparam int BUFW = 772;

  logic clk = 0, rst_n = 0, stopped = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_re, mem_we, rx_done;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, capacity;
  logic [1:0] mem_wstrb;

  always #2.5 clk = ~clk;

  rx_ring_engine i_rx_ring_engine (
    .clk(clk), .rst_n(rst_n), .stopped(stopped),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata), .rx_done(rx_done), .capacity(capacity)
  );

  int tests = 0, fails = 0;
  logic [15:0] mem [int];

  typedef struct packed { logic [15:0] a; logic [15:0] d; logic [1:0] s; } wr_t;
  wr_t exp_q[$];

  int done_cnt = 0;
  logic [15:0] cap_at_done = 0, cap_after = 0;
  bit pending = 0;

  task automatic chk(bit ok, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // Memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
    if (mem_we) begin
      logic [15:0] w;
      w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
      if (mem_wstrb[1]) w[15:8] = mem_wdata[15:8];
      if (mem_wstrb[0]) w[7:0]  = mem_wdata[7:0];
      mem[int'(mem_addr)] = w;
    end
  end

  // Monitor: compare every write with the scoreboard, track rx_done
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected memory write at address", int'(mem_addr), -1);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.a, "R4 write address", int'(mem_addr), int'(e.a));
          chk(mem_wdata == e.d && mem_wstrb == e.s, "R5 write data/strobe",
              int'({mem_wdata, 2'b00} | mem_wstrb), int'({e.d, 2'b00} | e.s));
        end
      end
      if (rx_done) begin
        done_cnt++;
        cap_at_done = capacity;
        pending = 1;
      end else if (pending) begin
        cap_after = capacity;
        pending = 0;
      end
    end
  end

  task automatic set_flag(int e, logic [7:0] f);
    mem[DESC + e*4 + 1] = {f, 8'h00};
  endtask

  task automatic push_frame(int n, int slot, logic [7:0] seed);
    int keep;
    keep = (n > 1544) ? 1544 : n;
    for (int j = 0; j < keep; j++) begin
      logic [7:0] b;
      wr_t w;
      b = seed + 8'(j * 7);
      w.a = 16'(BUFB + slot*BUFW + j/2);
      w.d = (j % 2 == 0) ? {b, 8'h00} : {8'h00, b};
      w.s = (j % 2 == 0) ? 2'b10 : 2'b01;
      exp_q.push_back(w);
    end
    exp_q.push_back(wr_t'{a: 16'(DESC + slot*4 + 3),
                          d: {8'(keep), 8'(keep >> 8)}, s: 2'b11});
    exp_q.push_back(wr_t'{a: 16'(DESC + slot*4 + 1), d: 16'h0300, s: 2'b10});
  endtask

  task automatic send_frame(int n, int slot, logic [7:0] seed, bit gaps, string tag);
    int d0;
    if (slot >= 0) push_frame(n, slot, seed);
    d0 = done_cnt;
    for (int j = 0; j < n; j++) begin
      if (gaps && (j % 3 == 1)) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data  = seed + 8'(j * 7);
      in_last  = (j == n - 1);
      #1;
      if (j == 0) chk(in_ready == 0, {tag, " R8 ready low at frame start"}, int'(in_ready), 0);
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 0; in_last = 0; in_data = 0;
    chk(in_ready == 0, {tag, " R8 ready low after last beat"}, int'(in_ready), 0);
    if (slot >= 0) begin
      for (int k = 0; k < 50 && done_cnt == d0; k++) @(negedge clk);
      @(negedge clk);
      chk(done_cnt == d0 + 1, {tag, " R6 one rx_done"}, done_cnt - d0, 1);
    end else begin
      repeat (10) @(negedge clk);
      chk(done_cnt == d0, {tag, " R7 no rx_done on drop"}, done_cnt - d0, 0);
    end
    chk(exp_q.size() == 0, {tag, " R5 all expected writes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) set_flag(e, 8'h00);
    repeat (3) @(negedge clk);
    chk(capacity == 0, "R1 capacity at reset", int'(capacity), 0);
    chk(in_ready == 0, "R1 ready at reset", int'(in_ready), 0);
    chk(rx_done == 0, "R1 rx_done at reset", int'(rx_done), 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk(capacity == 0, "R9 no entry handed", int'(capacity), 0);

    // Single entry 0 handed; index 0
    set_flag(0, 8'h80);
    repeat (40) @(negedge clk);
    chk(capacity == 1544, "R9 entry handed", int'(capacity), 1544);
    send_frame(5, 0, 8'h11, 0, "f1");
    chk(cap_at_done == 1544, "R9 capacity in done cycle", int'(cap_at_done), 1544);
    chk(cap_after == 0, "R9 capacity after done", int'(cap_after), 0);

    // Index 1: entry 1 is 0x81 (skipped), entry 2 usable
    set_flag(1, 8'h81);
    set_flag(2, 8'h80);
    repeat (40) @(negedge clk);
    send_frame(4, 2, 8'h40, 1, "f2 R2");

    // Index 2 now; entry 2 handed again is the search start, so hand 1? no: show skip at index-1
    // Advance index to 3 with a frame into entry 3
    set_flag(3, 8'h80);
    send_frame(2, 3, 8'h5a, 0, "f3");
    // Index 3: only entry 2 (index-1) is usable -> dropped
    set_flag(2, 8'h80);
    repeat (40) @(negedge clk);
    send_frame(3, -1, 8'h70, 0, "f4 R3 skip");
    chk(capacity == 1544, "R9 entry behind index still counted", int'(capacity), 1544);

    // Index 3: entry 0 handed, found after wrap
    set_flag(0, 8'h80);
    send_frame(6, 0, 8'h23, 1, "f5 R3 wrap");
    // Index 4 (not slot+1): search 4..15,0,1,2 -> last examinable entry 2, long frame
    send_frame(1600, 2, 8'h01, 0, "f6 R11");

    // Stopped: index 5
    stopped = 1;
    set_flag(5, 8'h80);
    repeat (40) @(negedge clk);
    chk(capacity == 0, "R10 capacity while stopped", int'(capacity), 0);
    send_frame(4, -1, 8'h99, 0, "f7 R10");
    stopped = 0;
    repeat (40) @(negedge clk);
    chk(capacity == 1544, "R9 capacity after restart", int'(capacity), 1544);
    send_frame(7, 5, 8'hc3, 1, "f8 R6 index");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule